// File: doc/BRIEF.md
# Single-Wire Byte Exchange Controller

This block trades one byte in each direction with a partner over a single shared wire. One end acts as master and the other as slave, chosen by the `is_master` input when `start` is pulsed. The two ends first synchronise by each sending a zero start bit. They then alternate bit by bit until a full byte has gone each way. Each bit on the wire is one high phase followed by one low phase. A receiver tells the value apart by comparing the lengths of the two phases, so no fixed threshold is needed.

A single shift register holds the byte to send when the exchange starts and the byte received when it ends. Outgoing bits leave at the least significant end. Incoming bits enter at the most significant end. If a receive phase lasts too long, the exchange is abandoned at once and flagged. The wire is modelled as a drive-enable and drive-value pair plus a sampled input; when nobody drives it, a pull-up keeps the wire high.

Controller states:
- `ST_IDLE`: waiting for `start`.
- `ST_SYNC_TX`: sending the start bit.
- `ST_SYNC_RX`: receiving the partner's start bit.
- `ST_DATA_TX`: sending one data bit.
- `ST_DATA_RX`: receiving one data bit.

Transitions:
- `ST_IDLE`→`ST_SYNC_TX` on start as master.
- `ST_IDLE`→`ST_SYNC_RX` on start as slave.
- `ST_SYNC_TX`→`ST_SYNC_RX` for the master and →`ST_DATA_RX` for the slave, when the bit has been sent.
- `ST_SYNC_RX`→`ST_DATA_TX` for the master and →`ST_SYNC_TX` for the slave, when the bit has been received.
- `ST_DATA_TX`↔`ST_DATA_RX` alternate once per bit.
- `ST_DATA_RX`→`ST_IDLE` (master) or `ST_DATA_TX`→`ST_IDLE` (slave) when the last bit completes.
- Any receive state→`ST_IDLE` on a timeout.

Top module: `swire_xchg`

## Requirements
- R1: With `is_master` high at `start`, the block is the first end to drive the wire: it sends a 0 start bit, then receives the partner's start bit.
- R2: With `is_master` low at `start`, the block first receives the partner's start bit and only then drives its own 0 start bit.
- R3: A transmitted bit is a high phase followed by a low phase, after which `line_oe` drops. Bit 0 is SHORT_CYC cycles high then LONG_CYC cycles low. Bit 1 is LONG_CYC cycles high then SHORT_CYC cycles low. `line_out` is the driven level while `line_oe` is high.
- R4: A received bit is 1 when the number of high samples is strictly greater than the number of low samples in the low phase that follows, and 0 otherwise. Any phase lengths below the timeout are accepted.
- R5: After the handshake, BYTE_W data bits are exchanged least significant bit first. The master sends each bit and then receives one; the slave receives and then sends. The bits the block drives are 0, then tx_byte[0], tx_byte[1], and so on in that order.
- R6: When `done` rises without `error`, `rx_byte` equals the byte the partner sent.
- R7: If a receive phase (waiting for the initial high, the high phase or the low phase) lasts RX_TMO_CYC samples, the exchange stops at once. `done` and `error` are raised and the wire is released.
- R8: `done` is a one-cycle pulse at the end of each exchange. `error` is high only in a cycle where `done` is high.
- R9: A `start` pulse, and any change of `tx_byte` or `is_master`, while an exchange is in progress has no effect on it. While idle without `start`, `rx_byte` holds its value.
- R10: After reset, `line_oe`, `done` and `error` are low and the block is idle.
- R11: The block never transmits while it is receiving. `line_oe` is low whenever no bit is being sent, including at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | Role for the exchange, sampled with `start` (1 = master) |
| start | input | 1 | Begin an exchange (acted on only when idle) |
| tx_byte | input | BYTE_W | Byte to send, sampled with `start` |
| line_in | input | 1 | Sampled level of the shared wire |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Level driven when `line_oe` is high |
| rx_byte | output | BYTE_W | Received byte, valid when `done` is high and `error` is low |
| done | output | 1 | One-cycle end-of-exchange pulse |
| error | output | 1 | Timeout abort, high only together with `done` |

## Verification
The situation hardest to reach from the ports is a partner that goes silent partway through the data bits, and a partner whose phase lengths differ from this block's own timing. Two instances running against each other never produce either case. The bench therefore adds a behavioural partner that drives the wire directly. It sends bits with unusual high and low lengths to exercise the comparison decoder. It can also stop after a chosen number of bits, so the slave times out in the middle of the data phase rather than during the handshake.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_TX,
        ST_SYNC_RX,
        ST_DATA_TX,
        ST_DATA_RX
    } xchg_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HIGH,
        TX_LOW
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT_HI,
        RX_HI,
        RX_LO
    } rx_state_e;

endpackage

// File: rtl/swire_bit_tx.sv
module swire_bit_tx
    import swire_pkg::*;
#(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic bit_val,
    output logic drive_en,
    output logic drive_val,
    output logic fin
);
    localparam int CW = $clog2(LONG_CYC + 1);

    tx_state_e      st;
    logic [CW-1:0]  cnt;
    logic           val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TX_IDLE;
            cnt <= '0;
            val <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                TX_IDLE: begin
                    if (go) begin
                        val <= bit_val;
                        st  <= TX_HIGH;
                        cnt <= bit_val ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
                    end
                end
                TX_HIGH: begin
                    if (cnt == '0) begin
                        st  <= TX_LOW;
                        cnt <= val ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                TX_LOW: begin
                    if (cnt == '0) begin
                        st  <= TX_IDLE;
                        fin <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign drive_en  = (st != TX_IDLE);
    assign drive_val = (st == TX_HIGH);

endmodule

// File: rtl/swire_bit_rx.sv
module swire_bit_rx
    import swire_pkg::*;
#(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic line,
    output logic active,
    output logic fin,
    output logic bit_out,
    output logic tmo
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC - 1);

    rx_state_e      st;
    logic [CW-1:0]  hcnt;
    logic [CW-1:0]  lcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            hcnt    <= '0;
            lcnt    <= '0;
            fin     <= 1'b0;
            bit_out <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    if (go) begin
                        st   <= RX_WAIT_HI;
                        hcnt <= '0;
                        lcnt <= '0;
                        tmo  <= 1'b0;
                    end
                end
                RX_WAIT_HI: begin
                    if (line) begin
                        st   <= RX_HI;
                        hcnt <= CW'(1);
                    end else if (lcnt == LIMIT) begin
                        st  <= RX_IDLE;
                        fin <= 1'b1;
                        tmo <= 1'b1;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                RX_HI: begin
                    if (!line) begin
                        st   <= RX_LO;
                        lcnt <= CW'(1);
                    end else if (hcnt == LIMIT) begin
                        st  <= RX_IDLE;
                        fin <= 1'b1;
                        tmo <= 1'b1;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                RX_LO: begin
                    if (line) begin
                        st      <= RX_IDLE;
                        fin     <= 1'b1;
                        bit_out <= (hcnt > lcnt);
                    end else if (lcnt == LIMIT) begin
                        st  <= RX_IDLE;
                        fin <= 1'b1;
                        tmo <= 1'b1;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign active = (st != RX_IDLE);

endmodule

// File: rtl/swire_xchg.sv
module swire_xchg
    import swire_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int SHORT_CYC  = 4,
    parameter int LONG_CYC   = 16,
    parameter int RX_TMO_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              line_in,
    output logic              line_oe,
    output logic              line_out,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              done,
    output logic              error
);
    localparam int BCW = $clog2(BYTE_W + 1);

    xchg_state_e        state;
    xchg_state_e        nxt;
    logic               role_m;
    logic [BYTE_W-1:0]  sr;
    logic [BCW-1:0]     bits_left;
    logic               fell_bit;
    logic               tx_go;
    logic               rx_go;
    logic               tx_val;
    logic               tx_fin;
    logic               rx_fin;
    logic               rx_bit;
    logic               rx_tmo;
    logic               rx_busy;
    logic               last;

    assign last = (bits_left == BCW'(1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (start) nxt = is_master ? ST_SYNC_TX : ST_SYNC_RX;
            ST_SYNC_TX:
                if (tx_fin) nxt = role_m ? ST_SYNC_RX : ST_DATA_RX;
            ST_SYNC_RX:
                if (rx_fin) nxt = rx_tmo ? ST_IDLE : (role_m ? ST_DATA_TX : ST_SYNC_TX);
            ST_DATA_TX:
                if (tx_fin) nxt = (!role_m && last) ? ST_IDLE : ST_DATA_RX;
            ST_DATA_RX:
                if (rx_fin) nxt = (rx_tmo || (role_m && last)) ? ST_IDLE : ST_DATA_TX;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs, datapath and bit launches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            role_m    <= 1'b0;
            sr        <= '0;
            bits_left <= '0;
            fell_bit  <= 1'b0;
            tx_go     <= 1'b0;
            rx_go     <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            tx_go <= (nxt != state) && (nxt == ST_SYNC_TX || nxt == ST_DATA_TX);
            rx_go <= (nxt != state) && (nxt == ST_SYNC_RX || nxt == ST_DATA_RX);
            done  <= (state != ST_IDLE) && (nxt == ST_IDLE);
            error <= (state != ST_IDLE) && (nxt == ST_IDLE) && rx_fin && rx_tmo;

            if (state == ST_IDLE && start) begin
                sr     <= tx_byte;
                role_m <= is_master;
            end

            if ((state == ST_SYNC_RX && nxt == ST_DATA_TX) ||
                (state == ST_SYNC_TX && nxt == ST_DATA_RX))
                bits_left <= BCW'(BYTE_W);
            else if ((role_m && state == ST_DATA_RX && nxt != ST_DATA_RX) ||
                     (!role_m && state == ST_DATA_TX && nxt != ST_DATA_TX))
                bits_left <= bits_left - 1'b1;

            if (state == ST_DATA_RX && rx_fin && !rx_tmo) begin
                fell_bit <= sr[0];
                sr       <= {rx_bit, sr[BYTE_W-1:1]};
            end
        end
    end

    assign tx_val  = (state == ST_DATA_TX) && (role_m ? sr[0] : fell_bit);
    assign rx_byte = sr;

    swire_bit_tx #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (tx_go),
        .bit_val   (tx_val),
        .drive_en  (line_oe),
        .drive_val (line_out),
        .fin       (tx_fin)
    );

    swire_bit_rx #(
        .TMO_CYC (RX_TMO_CYC)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (rx_go),
        .line    (line_in),
        .active  (rx_busy),
        .fin     (rx_fin),
        .bit_out (rx_bit),
        .tmo     (rx_tmo)
    );

endmodule

// File: rtl/swire_xchg_chk.sv
module swire_xchg_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              error,
    input logic              line_oe,
    input logic              idle,
    input logic              rx_busy,
    input logic [BYTE_W-1:0] rx_byte
);

    // R8: end pulse lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: error only accompanies done
    a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R11: wire released when the exchange ends
    a_r11_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !line_oe);

    // R11: transmit and receive never overlap
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_oe && rx_busy));

    // R10: idle controller does not drive the wire
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !line_oe);

    // R9: idle register holds without a start
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> $stable(rx_byte));

endmodule

bind swire_xchg swire_xchg_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .error   (error),
    .line_oe (line_oe),
    .idle    (state == swire_pkg::ST_IDLE),
    .rx_busy (rx_busy),
    .rx_byte (rx_byte)
);

// File: tb/swire_xchg_tb.sv
`timescale 1ns/1ps
module swire_xchg_tb_top;
    localparam int S = 4;
    localparam int L = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       dut_master = 1'b0, dut_start = 1'b0;
    logic [7:0] dut_tx = '0;
    logic       peer_master = 1'b0, peer_start = 1'b0;
    logic [7:0] peer_tx = '0;
    logic       force_low = 1'b0, bench_oe = 1'b0, bench_val = 1'b0;

    logic       line;
    logic       dut_oe, dut_out, dut_done, dut_error;
    logic [7:0] dut_rx;
    logic       peer_oe, peer_out, peer_done, peer_error;
    logic [7:0] peer_rx;

    assign line = force_low ? 1'b0 : bench_oe ? bench_val :
                  dut_oe ? dut_out : peer_oe ? peer_out : 1'b1;

    swire_xchg dut_i (
        .clk(clk), .rst_n(rst_n), .is_master(dut_master), .start(dut_start),
        .tx_byte(dut_tx), .line_in(line), .line_oe(dut_oe), .line_out(dut_out),
        .rx_byte(dut_rx), .done(dut_done), .error(dut_error));

    swire_xchg peer_i (
        .clk(clk), .rst_n(rst_n), .is_master(peer_master), .start(peer_start),
        .tx_byte(peer_tx), .line_in(line), .line_oe(peer_oe), .line_out(peer_out),
        .rx_byte(peer_rx), .done(peer_done), .error(peer_error));

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural monitor and per-clock reference checks
    int         cyc = 0;
    int         dut_done_cnt = 0, peer_done_cnt = 0;
    logic       dut_last_err = 1'b0, peer_last_err = 1'b0;
    logic [7:0] dut_last_rx = '0, peer_last_rx = '0;
    int         dut_rises[$];
    int         peer_rises[$];
    int         bit_log[$];
    logic       dut_oe_q = 1'b0, peer_oe_q = 1'b0, dut_done_q = 1'b0;
    int         hi_n = 0, lo_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (dut_oe && !dut_oe_q)   dut_rises.push_back(cyc);
            if (peer_oe && !peer_oe_q) peer_rises.push_back(cyc);
            if (dut_done) begin
                dut_done_cnt++;
                dut_last_err = dut_error;
                dut_last_rx  = dut_rx;
            end
            if (peer_done) begin
                peer_done_cnt++;
                peer_last_err = peer_error;
                peer_last_rx  = peer_rx;
            end
            if (dut_oe && (peer_oe || bench_oe)) chk(1'b0, "R11 contention", 1, 0);
            if (dut_error && !dut_done)          chk(1'b0, "R8 error without done", 1, 0);
            if (dut_done && dut_done_q)          chk(1'b0, "R8 done width", 2, 1);
            if (dut_oe) begin
                if (dut_out) hi_n++;
                else         lo_n++;
            end else if (hi_n != 0 || lo_n != 0) begin
                if (hi_n == S && lo_n == L)      bit_log.push_back(0);
                else if (hi_n == L && lo_n == S) bit_log.push_back(1);
                else begin
                    bit_log.push_back(2);
                    chk(1'b0, "R3 phase lengths hi*100+lo", hi_n*100+lo_n, 0);
                end
                hi_n = 0;
                lo_n = 0;
            end
            dut_oe_q   = dut_oe;
            peer_oe_q  = peer_oe;
            dut_done_q = dut_done;
        end
    end

    task automatic check_bits(input int idx0, input logic [7:0] b, input string req);
        chk(bit_log.size() - idx0 == 9, {req, " bit count"}, bit_log.size() - idx0, 9);
        if (bit_log.size() - idx0 == 9) begin
            chk(bit_log[idx0] == 0, {req, " start bit"}, bit_log[idx0], 0);
            for (int i = 0; i < 8; i++)
                chk(bit_log[idx0+1+i] == int'(b[i]), {req, " data bit order"},
                    bit_log[idx0+1+i], int'(b[i]));
        end
    endtask

    task automatic xchg(input bit dm, input logic [7:0] db, input logic [7:0] pb, input bit poke);
        int d0 = dut_done_cnt;
        int p0 = peer_done_cnt;
        int r0 = dut_rises.size();
        int q0 = peer_rises.size();
        int b0 = bit_log.size();
        @(negedge clk);
        dut_master = dm; peer_master = !dm; dut_tx = db; peer_tx = pb;
        dut_start = 1'b1; peer_start = 1'b1;
        @(negedge clk);
        dut_start = 1'b0; peer_start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            dut_master = !dm; dut_tx = ~db; dut_start = 1'b1;   // R9 stimulus
            @(negedge clk);
            dut_start = 1'b0;
        end
        for (int k = 0; k < 3000 && (dut_done_cnt == d0 || peer_done_cnt == p0); k++)
            @(negedge clk);
        chk(dut_done_cnt == d0 + 1, "R8 dut done once", dut_done_cnt - d0, 1);
        chk(peer_done_cnt == p0 + 1, "R8 peer done once", peer_done_cnt - p0, 1);
        chk(!dut_last_err, "R7 no error", int'(dut_last_err), 0);
        chk(dut_last_rx == pb, poke ? "R9 dut result" : "R6 dut result", dut_last_rx, pb);
        chk(peer_last_rx == db, poke ? "R9 peer result" : "R6 peer result", peer_last_rx, db);
        check_bits(b0, db, "R5");
        if (dut_rises.size() > r0 && peer_rises.size() > q0) begin
            if (dm) chk(dut_rises[r0] < peer_rises[q0], "R1 master drives first",
                        dut_rises[r0], peer_rises[q0]);
            else    chk(peer_rises[q0] < dut_rises[r0], "R2 slave drives second",
                        dut_rises[r0], peer_rises[q0]);
        end else chk(1'b0, "R1 drive seen", 0, 1);
        chk(!dut_oe, "R11 released after done", int'(dut_oe), 0);
        dut_master = dm;
    endtask

    // behavioural partner driving the wire directly
    task automatic bench_bit(input int hi, input int lo);
        @(negedge clk);
        bench_oe = 1'b1; bench_val = 1'b1;
        repeat (hi) @(negedge clk);
        bench_val = 1'b0;
        repeat (lo) @(negedge clk);
        bench_oe = 1'b0;
    endtask

    task automatic wait_dut_bit();
        for (int k = 0; k < 400 && !dut_oe; k++) @(negedge clk);
        for (int k = 0; k < 400 && dut_oe; k++)  @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic bench_master(input logic [7:0] db, input logic [7:0] bb, input int stop_at);
        int d0 = dut_done_cnt;
        int b0 = bit_log.size();
        @(negedge clk);
        dut_master = 1'b0; dut_tx = db; dut_start = 1'b1;
        @(negedge clk);
        dut_start = 1'b0;
        repeat (3) @(negedge clk);
        bench_bit(S, L);
        wait_dut_bit();
        for (int i = 0; i < 8 && i < stop_at; i++) begin
            if (bb[i]) bench_bit(40, 30);
            else       bench_bit(2, 30);
            wait_dut_bit();
        end
        for (int k = 0; k < 1000 && dut_done_cnt == d0; k++) @(negedge clk);
        chk(dut_done_cnt == d0 + 1, "R8 done after partner", dut_done_cnt - d0, 1);
        if (stop_at >= 8) begin
            chk(!dut_last_err, "R4 no error", int'(dut_last_err), 0);
            chk(dut_last_rx == bb, "R4 compare decode", dut_last_rx, bb);
            check_bits(b0, db, "R3");
        end else begin
            chk(dut_last_err, "R7 mid-byte abort", int'(dut_last_err), 1);
            chk(!dut_oe, "R7 released", int'(dut_oe), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int d0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dut_oe, "R10 line_oe", int'(dut_oe), 0);
        chk(!dut_done, "R10 done", int'(dut_done), 0);
        chk(!dut_error, "R10 error", int'(dut_error), 0);

        xchg(1'b1, 8'hA5, 8'h3C, 1'b0);
        xchg(1'b0, 8'hA5, 8'h3C, 1'b0);
        xchg(1'b1, 8'h00, 8'hFF, 1'b0);
        xchg(1'b0, 8'hFF, 8'h00, 1'b0);
        xchg(1'b1, 8'h01, 8'h80, 1'b0);
        xchg(1'b1, 8'h5A, 8'hC3, 1'b1);
        xchg(1'b0, 8'h96, 8'h69, 1'b1);

        bench_master(8'h2D, 8'hB4, 8);
        bench_master(8'hE1, 8'h0F, 3);

        // R7: partner never answers the master's start bit
        d0 = dut_done_cnt;
        @(negedge clk);
        dut_master = 1'b1; dut_tx = 8'h77; dut_start = 1'b1;
        @(negedge clk);
        dut_start = 1'b0;
        for (int k = 0; k < 500 && dut_done_cnt == d0; k++) @(negedge clk);
        chk(dut_done_cnt == d0 + 1, "R7 silent partner done", dut_done_cnt - d0, 1);
        chk(dut_last_err, "R7 silent partner error", int'(dut_last_err), 1);
        chk(!dut_oe, "R7 released", int'(dut_oe), 0);

        // R7: wire shorted low while the slave waits for the initial high
        d0 = dut_done_cnt;
        @(negedge clk);
        force_low = 1'b1; dut_master = 1'b0; dut_start = 1'b1;
        @(negedge clk);
        dut_start = 1'b0;
        for (int k = 0; k < 500 && dut_done_cnt == d0; k++) @(negedge clk);
        chk(dut_done_cnt == d0 + 1, "R7 stuck low done", dut_done_cnt - d0, 1);
        chk(dut_last_err, "R7 stuck low error", int'(dut_last_err), 1);
        force_low = 1'b0;
        repeat (4) @(negedge clk);

        xchg(1'b0, 8'h3E, 8'hD1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule